// File: doc/BRIEF.md
# Dual-Side Hardware Semaphore Bank

This block holds a small set of one-bit hardware locks that two agents share: a host on a simple synchronous register port and an embedded coprocessor core on a dedicated request port. Each lock is free, held by the host, or held by the coprocessor. An agent can only take a free lock and can only give back a lock it holds. Software on either side uses the locks to guard shared data structures without any handshake through memory.

The host sees all locks in the low byte of one 16-bit register. A write carries a per-lock select mask in its upper byte and the requested value per lock in its lower byte, so one write can take some locks, give back others and leave the rest alone. A read returns a 1 for each lock the host currently holds. The coprocessor names one lock per request, asks to take or to give it back, and learns one cycle after a take whether it got the lock. It also sees which locks it holds. When both sides ask for the same free lock in the same cycle, the coprocessor always wins.

Top module: `hw_sema_bank`

## Requirements
- R1: After the active-low reset every lock is free: a host read of the register returns 0x0000, cpHeld is 0, cpGrant is 0 and hostAck is 0.
- R2: On a host write to the register address (default 0), a lock whose select bit hostWdata[8+i] is 1 and value bit hostWdata[i] is 1 is taken by the host if it is free; a lock whose select bit is 0 is unchanged. Writing 0x5050 to an idle bank makes a later read return 0x0050.
- R3: On a host write, a lock with select bit 1 and value bit 0 that the host holds becomes free; writing 0xFF00 gives back every host-held lock, after which the host reads 0x0000.
- R4: A host read returns 0 in bits [15:8] and, in bit i, 1 exactly when the host holds lock i.
- R5: A host attempt to take a lock the coprocessor holds has no effect; that bit reads 0 to the host and the lock stays in cpHeld.
- R6: A coprocessor take request (cpReq=1, cpRelease=0, lock number on cpIndex) succeeds when the lock is free or already held by the coprocessor: in the next cycle cpGrant is 1 and cpHeld[cpIndex] is 1. When the host holds the lock, cpGrant is 0 in the next cycle and nothing changes.
- R7: A give-back from the side that does not hold a lock is ignored: a host write with select 1, value 0 leaves a coprocessor-held lock held, and a coprocessor give-back (cpReq=1, cpRelease=1) leaves a host-held lock held.
- R8: A coprocessor give-back of a lock it holds frees the lock in the next cycle, and the host can then take it.
- R9: When the host and the coprocessor ask for the same free lock in the same cycle, the coprocessor gets it (cpGrant 1, cpHeld bit 1) and the host read bit stays 0.
- R10: Every cycle with hostStb high is acknowledged by hostAck high in the following cycle; read data is presented in that same cycle, write acknowledges carry 0x0000, and an access to any address other than the register address returns 0x0000 on read and changes no lock on write.
- R11: Asserting the reset at any time, including mid-operation, returns every lock to free at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostStb | input | 1 | Host access strobe, one cycle per access |
| hostWe | input | 1 | Host write enable (1 write, 0 read) |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | 16 | Host write data: select mask [15:8], values [7:0] |
| hostRdata | output | 16 | Host read data, valid with hostAck |
| hostAck | output | 1 | Host acknowledge, one cycle after the strobe |
| cpReq | input | 1 | Coprocessor request valid |
| cpRelease | input | 1 | Coprocessor request kind: 0 take, 1 give back |
| cpIndex | input | 3 | Lock number of the coprocessor request |
| cpGrant | output | 1 | Take succeeded, in the cycle after the request |
| cpHeld | output | 8 | Locks currently held by the coprocessor |

## Verification
The host register is driven with mixed select/value patterns (all-select sets, partial masks with select-0 bits, a full give-back and a partial give-back) so that a decode that ignores the mask, confuses select with value or leaks the upper byte into readback shows up as a wrong read value. Ownership is tried from both sides against locks held by the other side, which separates a correct per-side owner record from a single shared bit that either side could clear or steal. The same-cycle conflict on one free lock tells a fixed coprocessor-first rule from host-first or double grant, and accesses to a second address plus an asynchronous reset in the middle of a run show that misses change nothing and that reset frees everything.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

  // Number of locks in the bank; host data width follows from it.
  localparam int HSEM_COUNT = 8;
  localparam int HSEM_IDX_W = $clog2(HSEM_COUNT);
  localparam int HSEM_DATA_W = 2 * HSEM_COUNT;

  typedef enum logic [1:0] {
    SEM_FREE = 2'b00,
    SEM_HOST = 2'b01,
    SEM_COP  = 2'b10
  } semState_t;

  // Strobes from the request decode to the lock datapath.
  typedef struct packed {
    logic [HSEM_COUNT-1:0] hostSet;
    logic [HSEM_COUNT-1:0] hostClr;
    logic [HSEM_COUNT-1:0] cpSet;
    logic [HSEM_COUNT-1:0] cpClr;
    logic                  hostRd;
  } hsemStrobe_t;

endpackage

// File: rtl/hsem_ctrl.sv
module hsem_ctrl
  import hsem_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostStb,
  input  logic                  hostWe,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [HSEM_DATA_W-1:0] hostWdata,
  input  logic                  cpReq,
  input  logic                  cpRelease,
  input  logic [HSEM_IDX_W-1:0] cpIndex,
  output hsemStrobe_t           strobes,
  output logic                  hostAck
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [HSEM_COUNT-1:0] ONE = HSEM_COUNT'(1);

  logic                  addrHit;
  logic                  hostWr;
  logic [HSEM_COUNT-1:0] selMask;
  logic [HSEM_COUNT-1:0] selVal;
  logic [HSEM_COUNT-1:0] cpOneHot;
  logic                  ackQ;

  assign addrHit  = (hostAddr == MY_ADDR);
  assign hostWr   = hostStb && hostWe && addrHit;
  assign selMask  = hostWdata[HSEM_DATA_W-1:HSEM_COUNT];
  assign selVal   = hostWdata[HSEM_COUNT-1:0];
  assign cpOneHot = ONE << cpIndex;

  always_comb begin
    strobes.hostSet = hostWr ? (selMask & selVal) : '0;
    strobes.hostClr = hostWr ? (selMask & ~selVal) : '0;
    strobes.cpSet   = (cpReq && !cpRelease) ? cpOneHot : '0;
    strobes.cpClr   = (cpReq && cpRelease) ? cpOneHot : '0;
    strobes.hostRd  = hostStb && !hostWe && addrHit;
  end

  // Every strobed access, hit or miss, is acknowledged one cycle later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= hostStb;
  end

  assign hostAck = ackQ;

endmodule

// File: rtl/hsem_datapath.sv
module hsem_datapath
  import hsem_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  hsemStrobe_t            strobes,
  output logic [HSEM_DATA_W-1:0] hostRdata,
  output logic [HSEM_COUNT-1:0]  hostView,
  output logic [HSEM_COUNT-1:0]  cpView,
  output logic                   cpGrant
);

  logic [HSEM_COUNT-1:0]  cpAvail;
  logic                   grantQ;
  logic [HSEM_DATA_W-1:0] rdQ;

  for (genvar i = 0; i < HSEM_COUNT; i++) begin : g_sem
    semState_t stateQ;
    semState_t stateNext;

    // Arbitration per lock: the coprocessor is served first on a free lock.
    always_comb begin
      stateNext = stateQ;
      unique case (stateQ)
        SEM_FREE: begin
          if (strobes.cpSet[i])        stateNext = SEM_COP;
          else if (strobes.hostSet[i]) stateNext = SEM_HOST;
        end
        SEM_HOST: if (strobes.hostClr[i]) stateNext = SEM_FREE;
        SEM_COP:  if (strobes.cpClr[i])   stateNext = SEM_FREE;
        default:  stateNext = SEM_FREE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateQ <= SEM_FREE;
      else       stateQ <= stateNext;
    end

    assign hostView[i] = (stateQ == SEM_HOST);
    assign cpView[i]   = (stateQ == SEM_COP);
    assign cpAvail[i]  = (stateQ != SEM_HOST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      rdQ    <= '0;
    end else begin
      grantQ <= |(strobes.cpSet & cpAvail);
      rdQ    <= strobes.hostRd ? {{HSEM_COUNT{1'b0}}, hostView} : '0;
    end
  end

  assign cpGrant   = grantQ;
  assign hostRdata = rdQ;

endmodule

// File: rtl/hw_sema_bank.sv
module hw_sema_bank
  import hsem_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostStb,
  input  logic                   hostWe,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic [HSEM_DATA_W-1:0] hostWdata,
  output logic [HSEM_DATA_W-1:0] hostRdata,
  output logic                   hostAck,
  input  logic                   cpReq,
  input  logic                   cpRelease,
  input  logic [HSEM_IDX_W-1:0]  cpIndex,
  output logic                   cpGrant,
  output logic [HSEM_COUNT-1:0]  cpHeld
);

  hsemStrobe_t           strobes;
  logic [HSEM_COUNT-1:0] hostView;

  hsem_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostStb  (hostStb),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .cpReq    (cpReq),
    .cpRelease(cpRelease),
    .cpIndex  (cpIndex),
    .strobes  (strobes),
    .hostAck  (hostAck)
  );

  hsem_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .hostRdata(hostRdata),
    .hostView (hostView),
    .cpView   (cpHeld),
    .cpGrant  (cpGrant)
  );

endmodule

// File: rtl/hsem_chk.sv
module hsem_chk
  import hsem_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  hostStb,
  input logic                  hostAck,
  input logic                  cpReq,
  input logic                  cpRelease,
  input logic [HSEM_IDX_W-1:0] cpIndex,
  input logic                  cpGrant,
  input logic [HSEM_COUNT-1:0] cpHeld,
  input logic [HSEM_COUNT-1:0] hostView
);

  // R10: each strobe is answered in the next cycle, and only then.
  a_r10_ack_follows_stb: assert property (@(posedge clk) disable iff (!rstN)
    hostStb |=> hostAck);
  a_r10_no_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    !hostStb |=> !hostAck);

  // R9: no lock is ever held by both sides.
  a_r9_exclusive_owner: assert property (@(posedge clk) disable iff (!rstN)
    (hostView & cpHeld) == '0);

  // R6: a grant follows a take request and the named lock is then held.
  a_r6_grant_after_take: assert property (@(posedge clk) disable iff (!rstN)
    (cpReq && !cpRelease) |=> (cpGrant == cpHeld[$past(cpIndex)]));
  a_r6_grant_needs_take: assert property (@(posedge clk) disable iff (!rstN)
    !(cpReq && !cpRelease) |=> !cpGrant);

  // R5, R7: the host can neither take nor free a coprocessor-held lock.
  a_r7_cp_lock_kept: assert property (@(posedge clk) disable iff (!rstN)
    !(cpReq && cpRelease) |=> ((cpHeld & $past(cpHeld)) == $past(cpHeld)));
  a_r5_no_host_steal: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hostView & $past(cpHeld)) == '0));

endmodule

bind hw_sema_bank hsem_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostStb  (hostStb),
  .hostAck  (hostAck),
  .cpReq    (cpReq),
  .cpRelease(cpRelease),
  .cpIndex  (cpIndex),
  .cpGrant  (cpGrant),
  .cpHeld   (cpHeld),
  .hostView (hostView)
);

// File: tb/hw_sema_bank_tb.sv
`timescale 1ns/1ps
module hw_sema_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostStb = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostAck;
  logic        cpReq = 1'b0;
  logic        cpRelease = 1'b0;
  logic [2:0]  cpIndex = '0;
  logic        cpGrant;
  logic [7:0]  cpHeld;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  hw_sema_bank u_dut (
    .clk(clk), .rstN(rstN),
    .hostStb(hostStb), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostAck(hostAck),
    .cpReq(cpReq), .cpRelease(cpRelease), .cpIndex(cpIndex),
    .cpGrant(cpGrant), .cpHeld(cpHeld)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // Monitor: every acknowledge pops one expected read value.
  always @(negedge clk) begin
    if (rstN && hostAck) begin
      if (expQ.size() == 0) begin
        check(16'hDEAD, 16'h0000, "R10 ack without access");
      end else begin
        check(hostRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  // Driver: one host access, expected acknowledge data queued.
  task automatic hostAccess(input logic we, input logic [3:0] addr,
                            input logic [15:0] wd, input logic [15:0] expRd,
                            input string tag);
    @(negedge clk);
    hostStb = 1'b1; hostWe = we; hostAddr = addr; hostWdata = wd;
    expQ.push_back(expRd); tagQ.push_back(tag);
    @(negedge clk);
    hostStb = 1'b0; hostWe = 1'b0; hostWdata = '0; hostAddr = '0;
  endtask

  task automatic cpOp(input logic rel, input logic [2:0] idx,
                      input logic expGrant, input logic [7:0] expHeld,
                      input string tag);
    @(negedge clk);
    cpReq = 1'b1; cpRelease = rel; cpIndex = idx;
    @(negedge clk);
    cpReq = 1'b0; cpRelease = 1'b0;
    check({15'd0, cpGrant}, {15'd0, expGrant}, {tag, " grant"});
    check({8'd0, cpHeld}, {8'd0, expHeld}, {tag, " held"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({15'd0, hostAck}, 16'h0, "R1 ack idle");
    check({15'd0, cpGrant}, 16'h0, "R1 grant idle");
    check({8'd0, cpHeld}, 16'h0, "R1 cp held");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0000, "R1 read after reset");

    // R2, R4: masked set and readback
    hostAccess(1'b1, 4'd0, 16'h5050, 16'h0000, "R10 write ack data");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0050, "R2 R4 read after 0x5050");
    hostAccess(1'b1, 4'd0, 16'h0301, 16'h0000, "R2 partial write");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0051, "R2 unselected bits unchanged");

    // R3: give back all, then a partial give-back
    hostAccess(1'b1, 4'd0, 16'hFF00, 16'h0000, "R3 write 0xFF00");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0000, "R3 read after 0xFF00");
    hostAccess(1'b1, 4'd0, 16'h5050, 16'h0000, "R3 retake");
    hostAccess(1'b1, 4'd0, 16'h1000, 16'h0000, "R3 partial release");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0040, "R3 read after partial release");
    hostAccess(1'b1, 4'd0, 16'hFF00, 16'h0000, "R3 clean");

    // R6, R5, R7
    cpOp(1'b0, 3'd3, 1'b1, 8'h08, "R6 cp take free lock 3");
    hostAccess(1'b1, 4'd0, 16'h0808, 16'h0000, "R5 host take of cp lock");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0000, "R5 host bit reads 0");
    hostAccess(1'b1, 4'd0, 16'h0800, 16'h0000, "R7 host release of cp lock");
    @(negedge clk);
    check({8'd0, cpHeld}, 16'h0008, "R7 cp lock kept after host release");
    hostAccess(1'b1, 4'd0, 16'h0202, 16'h0000, "R2 host take lock 1");
    cpOp(1'b0, 3'd1, 1'b0, 8'h08, "R6 cp take of host lock");
    cpOp(1'b1, 3'd1, 1'b0, 8'h08, "R7 cp release of host lock");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0002, "R7 host lock kept");
    cpOp(1'b0, 3'd3, 1'b1, 8'h08, "R6 cp retake own lock");

    // R8
    cpOp(1'b1, 3'd3, 1'b0, 8'h00, "R8 cp release own lock");
    hostAccess(1'b1, 4'd0, 16'h0808, 16'h0000, "R8 host take freed lock");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h000A, "R8 host holds 1 and 3");

    // R9: same-cycle contention on lock 7
    @(negedge clk);
    hostStb = 1'b1; hostWe = 1'b1; hostAddr = 4'd0; hostWdata = 16'h8080;
    expQ.push_back(16'h0000); tagQ.push_back("R9 contention write ack");
    cpReq = 1'b1; cpRelease = 1'b0; cpIndex = 3'd7;
    @(negedge clk);
    hostStb = 1'b0; hostWe = 1'b0; hostWdata = '0; cpReq = 1'b0;
    check({15'd0, cpGrant}, 16'h1, "R9 cp wins grant");
    check({8'd0, cpHeld}, 16'h0080, "R9 cp holds lock 7");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h000A, "R9 host bit 7 stays 0");

    // R10: other address
    hostAccess(1'b1, 4'd1, 16'hFFFF, 16'h0000, "R10 miss write");
    hostAccess(1'b0, 4'd1, 16'h0, 16'h0000, "R10 miss read");
    hostAccess(1'b0, 4'd0, 16'h0, 16'h000A, "R10 miss write changed nothing");
    check({8'd0, cpHeld}, 16'h0080, "R10 cp locks unchanged");

    // R11: async reset mid-run
    @(negedge clk);
    #2 rstN = 1'b0;
    #1 check({8'd0, cpHeld}, 16'h0, "R11 cp locks freed at reset");
    @(negedge clk);
    rstN = 1'b1;
    hostAccess(1'b0, 4'd0, 16'h0, 16'h0000, "R11 host read after reset");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) check(16'(expQ.size()), 16'h0, "R10 missing ack");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule